// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block checks the address byte at the start of an I2C transfer against a 7-bit slave address set on an input port. It checks one bit at a time. Neighbouring logic detects the bus conditions and gives the block three signals. The first is a one-cycle strobe at each SCL sampling point. The second is the SDA level sampled at that point. The third is a one-cycle strobe when a START condition has been detected. The block returns three registered outputs: a match flag, a mismatch flag and the captured read/write bit.

Address bits arrive most-significant first. Each bit is compared against the current address input as it arrives. The first differing bit raises the mismatch flag on the following clock, and the flag stays high until the next START. The eighth strobe carries the read/write bit. On that strobe the block captures the bit and, if every address bit agreed, raises the match flag. Nothing changes after that until a new START.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `addr_hit`, `addr_miss` and `rd_wr` are all 0.
- R2: A `frm_start` pulse clears `addr_hit` and `addr_miss` on the next clock. It also makes the next counted strobe the most-significant address bit.
- R3: Address bits are taken most-significant first, one per `bit_stb`. A bit that differs from the matching `slv_addr` bit sets `addr_miss` on the clock edge that samples that strobe. The block does not wait for later bits.
- R4: Once set, `addr_miss` stays 1 through the rest of the frame, including the read/write bit. Only `frm_start` clears it.
- R5: `addr_hit` stays 0 during the seven address strobes. It becomes 1 on the clock edge that samples the eighth strobe, and only if all seven address bits matched.
- R6: On the eighth strobe, `sda_lvl` is stored in `rd_wr`: 1 means read and 0 means write. Its value has no effect on `addr_hit`.
- R7: `addr_hit` and `addr_miss` are never 1 at the same time.
- R8: Each bit is compared with `slv_addr` as it stands when that bit arrives. Changing `slv_addr` in the middle of a frame does not re-check bits that were already accepted.
- R9: After the eighth strobe, further `bit_stb` pulses leave `addr_hit`, `addr_miss` and `rd_wr` unchanged until the next `frm_start`.
- R10: `bit_stb` pulses that arrive before the first `frm_start` after reset have no effect on any output.
- R11: If `frm_start` and `bit_stb` are high in the same cycle, `frm_start` wins and that strobe is not counted as an address bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| slv_addr | input | 7 | Configured slave address, bit 6 compared first |
| bit_stb | input | 1 | One-cycle strobe at each SCL sampling point |
| sda_lvl | input | 1 | SDA level sampled at the strobe |
| frm_start | input | 1 | One-cycle strobe for a detected START condition |
| addr_hit | output | 1 | All address bits matched; set after the read/write bit |
| addr_miss | output | 1 | At least one address bit differed in this frame |
| rd_wr | output | 1 | Captured read/write bit, 1 = read |

## Verification
The bench sends a frame whose first mismatch is at the third bit. A design that waits for the end of the address would keep `addr_miss` low there, and a design that is not sticky would drop it on the later matching bits. Matching frames are checked after every one of the seven address strobes, so a design that raises `addr_hit` one bit early is caught. Matching frames with both read/write values catch a design that lets that bit affect the match. The bench also changes `slv_addr` in the middle of a frame, sends extra strobes after the eighth, sends strobes before any START, and sends a START and a strobe in the same cycle. A design that re-compares the whole address, keeps counting or loses the START priority ends with the wrong flags or the wrong captured bit.

// File: rtl/mam_pkg.sv
package mam_pkg;
  localparam int unsigned DEF_ADDR_W = 7;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_RW   = 2'd2,
    PH_DONE = 2'd3
  } mam_phase_e;
endpackage

// File: rtl/mam_rst_sync.sv
module mam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mam_bit_seq.sv
module mam_bit_seq
  import mam_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned IW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          frm_start,
  input  logic          bit_stb,
  output mam_phase_e    phase_o,
  output logic [IW-1:0] idx_o,
  output logic          take_o
);
  mam_phase_e    phase_q, phase_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          take;

  assign take = bit_stb && !frm_start &&
                ((phase_q == PH_ADDR) || (phase_q == PH_RW));

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (frm_start) begin
      phase_d = PH_ADDR;
      idx_d   = '0;
    end else if (take) begin
      if (phase_q == PH_ADDR) begin
        if (idx_q == IW'(ADDR_W - 1)) phase_d = PH_RW;
        else                          idx_d   = idx_q + 1'b1;
      end else begin
        phase_d = PH_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign take_o  = take;

  // R3: the bit index never runs past the last address bit
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_q <= IW'(ADDR_W - 1));

  // R2: a START always sends the sequencer back to the first address bit
  p_start_restart_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_start |=> (phase_q == PH_ADDR) && (idx_q == '0));
endmodule

// File: rtl/mam_flags.sv
module mam_flags
  import mam_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned IW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              frm_start,
  input  logic              take,
  input  mam_phase_e        phase,
  input  logic [IW-1:0]     idx,
  input  logic              sda_lvl,
  input  logic [ADDR_W-1:0] slv_addr,
  output logic              hit_o,
  output logic              miss_o,
  output logic              rw_o
);
  logic hit_q, hit_d;
  logic miss_q, miss_d;
  logic rw_q, rw_d;
  logic exp_bit;

  always_comb begin
    exp_bit = 1'b0;
    for (int k = 0; k < ADDR_W; k++) begin
      if (idx == IW'(k)) exp_bit = slv_addr[ADDR_W-1-k];
    end
  end

  always_comb begin
    hit_d  = hit_q;
    miss_d = miss_q;
    rw_d   = rw_q;
    if (frm_start) begin
      hit_d  = 1'b0;
      miss_d = 1'b0;
    end else if (take) begin
      if (phase == PH_ADDR) begin
        if (sda_lvl != exp_bit) miss_d = 1'b1;
      end else if (phase == PH_RW) begin
        rw_d  = sda_lvl;
        hit_d = !miss_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      rw_q   <= 1'b0;
    end else begin
      hit_q  <= hit_d;
      miss_q <= miss_d;
      rw_q   <= rw_d;
    end
  end

  assign hit_o  = hit_q;
  assign miss_o = miss_q;
  assign rw_o   = rw_q;

  // R7
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(hit_q && miss_q));

  // R4
  p_miss_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (miss_q && !frm_start) |=> miss_q);

  // R2
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_start |=> (!hit_q && !miss_q));

  // R5
  p_hit_on_rw_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(hit_q) |-> ($past(take) && ($past(phase) == PH_RW)));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import mam_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned IW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic              bit_stb,
  input  logic              sda_lvl,
  input  logic              frm_start,
  output logic              addr_hit,
  output logic              addr_miss,
  output logic              rd_wr
);
  logic          rst_ni;
  mam_phase_e    phase;
  logic [IW-1:0] idx;
  logic          take;

  mam_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  mam_bit_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .frm_start (frm_start),
    .bit_stb   (bit_stb),
    .phase_o   (phase),
    .idx_o     (idx),
    .take_o    (take)
  );

  mam_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .frm_start (frm_start),
    .take      (take),
    .phase     (phase),
    .idx       (idx),
    .sda_lvl   (sda_lvl),
    .slv_addr  (slv_addr),
    .hit_o     (addr_hit),
    .miss_o    (addr_miss),
    .rw_o      (rd_wr)
  );

  // R9
  p_done_stable_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    ((phase == PH_DONE) && !frm_start) |=>
      ($stable(addr_hit) && $stable(addr_miss) && $stable(rd_wr)));

  // R10
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    ((phase == PH_IDLE) && !frm_start) |=>
      ($stable(addr_hit) && $stable(addr_miss) && $stable(rd_wr)));
endmodule

// File: tb/i2c_addr_match_test.sv
module i2c_addr_match_test;
  logic       clk;
  logic       rst_n;
  logic [6:0] slv_addr;
  logic       bit_stb;
  logic       sda_lvl;
  logic       frm_start;
  logic       addr_hit;
  logic       addr_miss;
  logic       rd_wr;

  int n_run  = 0;
  int n_fail = 0;

  i2c_addr_match uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .slv_addr  (slv_addr),
    .bit_stb   (bit_stb),
    .sda_lvl   (sda_lvl),
    .frm_start (frm_start),
    .addr_hit  (addr_hit),
    .addr_miss (addr_miss),
    .rd_wr     (rd_wr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input int h, input int m);
    chk(req, int'(addr_hit), h);
    chk(req, int'(addr_miss), m);
    chk("R7", int'(addr_hit && addr_miss), 0);
  endtask

  task automatic pulse_start(input logic with_stb, input logic sda);
    @(negedge clk);
    frm_start = 1'b1;
    bit_stb   = with_stb;
    sda_lvl   = sda;
    @(negedge clk);
    frm_start = 1'b0;
    bit_stb   = 1'b0;
    chk_flags("R2", 0, 0);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_stb = 1'b1;
    sda_lvl = b;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  // sends 7 address bits and the R/W bit, checking flags after each
  task automatic send_frame(input logic [6:0] a, input logic rw, input int first_bad);
    for (int i = 0; i < 7; i++) begin
      send_bit(a[6-i]);
      if (first_bad >= 0 && i >= first_bad) chk_flags("R3 R4", 0, 1);
      else                                   chk_flags("R5", 0, 0);
    end
    send_bit(rw);
    if (first_bad >= 0) chk_flags("R4", 0, 1);
    else                chk_flags("R5", 1, 0);
    chk("R6", int'(rd_wr), int'(rw));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; bit_stb = 1'b0; sda_lvl = 1'b0; frm_start = 1'b0;
    slv_addr = 7'h63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_flags("R1", 0, 0);
    chk("R1", int'(rd_wr), 0);
  endtask

  task automatic t_before_start();
    for (int i = 0; i < 9; i++) begin
      send_bit(1'b1);
      chk_flags("R10", 0, 0);
      chk("R10", int'(rd_wr), 0);
    end
  endtask

  task automatic t_match_write();
    slv_addr = 7'h63;
    pulse_start(1'b0, 1'b0);
    send_frame(7'h63, 1'b0, -1);
  endtask

  task automatic t_match_read();
    pulse_start(1'b0, 1'b0);
    send_frame(7'h63, 1'b1, -1);
  endtask

  task automatic t_after_done();
    for (int i = 0; i < 5; i++) begin
      send_bit(1'b0);
      chk_flags("R9", 1, 0);
      chk("R9", int'(rd_wr), 1);
    end
  endtask

  task automatic t_mismatch();
    slv_addr = 7'h73;
    pulse_start(1'b0, 1'b0);
    send_frame(7'h63, 1'b1, 2);
    for (int i = 0; i < 3; i++) begin
      send_bit(1'b0);
      chk_flags("R9", 0, 1);
      chk("R9", int'(rd_wr), 1);
    end
  endtask

  task automatic t_recover();
    slv_addr = 7'h63;
    pulse_start(1'b0, 1'b0);
    send_frame(7'h63, 1'b0, -1);
  endtask

  task automatic t_addr_change();
    slv_addr = 7'h63;
    pulse_start(1'b0, 1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    chk_flags("R8", 0, 0);
    slv_addr = 7'h03;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    chk_flags("R8", 0, 0);
    send_bit(1'b1);
    chk_flags("R8", 1, 0);
    chk("R8", int'(rd_wr), 1);
  endtask

  task automatic t_start_priority();
    slv_addr = 7'h63;
    pulse_start(1'b1, 1'b0);
    chk_flags("R11", 0, 0);
    for (int i = 0; i < 7; i++) begin
      send_bit(slv_addr[6-i]);
      chk_flags("R11", 0, 0);
    end
    send_bit(1'b0);
    chk_flags("R11", 1, 0);
    chk("R11", int'(rd_wr), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_before_start();
        t_match_write();
        t_match_read();
        t_after_done();
        t_mismatch();
        t_recover();
        t_addr_change();
        t_start_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule